// File: doc/BRIEF.md
# Reference-Gated Frequency Meter

This block measures the frequency of one of several monitored clocks by counting its rising edges during a gate window timed by a reference clock. Software programs the window length, the monitored source, an optional pre-divider and a debug mode field through a small word-addressed register port in the reference domain. It turns the meter on with an enable bit and then requests a measurement with a run bit. Run clears itself once the count is final, and the count can then be read.

The gate is a single-bit level raised in the reference domain for exactly load+1 reference cycles. It crosses into the selected monitored clock's domain through two flops, and there it clears and then advances an edge counter. When the gate falls, the monitored side flips a completion toggle. That toggle returns to the reference domain through a two-flop synchronizer, and the reference side then copies the frozen count into the result field. With a 26 MHz reference and a load value of 511, the window is 512 reference cycles, so the result equals f_mon[MHz] × 512 / 26.

Top module: `freq_meter`

## Requirements
- R1: After reset the enable and run bits read 0, the result reads 0, the window field reads 511, and the mode, source and divisor fields read 0.
- R2: A write to word 0 sets enable from bit 0. A write with bit 1 and bit 0 set starts a measurement when enable was already 1, the meter is idle, the mode field is 00 and the source code is valid. Run (word 0 bit 1) then reads 1, and the gate rises together with run.
- R3: A run request written while enable was clear before that write does not start a measurement: run reads 0, and only enable is updated.
- R4: The gate stays high for exactly load+1 reference cycles, where load is word 1 bits [25:16]. The result is the number of monitored rising edges in that window, within ±2. With load 511 this gives result = f_mon × 512 / f_ref.
- R5: The source code in word 2 bits [14:8] selects monitored clock k for a code k below N_SRC. A code of N_SRC or above refuses a run request.
- R6: A non-zero mode field (word 2 bits [1:0]) refuses a run request. Only mode 00 allows a measurement.
- R7: A divisor value d in word 3 bits [31:24] makes the counter advance once every d+1 monitored edges. A value of 0 divides by 1.
- R8: Run clears itself when the count is final. The result (word 1 bits [CNT_W-1:0]) changes only on the cycle in which run falls.
- R9: The edge counter saturates at 2^CNT_W-1 and does not wrap.
- R10: Writing word 0 with bit 0 clear during a measurement clears enable and forces run to 0 on the next cycle. The previous result is kept, and a later measurement is correct.
- R11: Writes to words 1, 2 and 3 are ignored while a measurement, or the drain of an aborted one, is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Synchronous active-low reset, held long enough to reach the monitored side |
| mon_clk | input | N_SRC | Monitored clocks, one per source code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 control, 1 window/result, 2 mode/source, 3 divisor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr (combinational) |

## Verification
The bench builds the meter with N_SRC=4 and CNT_W=11. Four monitored clocks at 2, 0.8, 2.67 and 0.5 times the reference then exercise selection, fast and slow ratios, and the refusal of a source code one past the last valid one. The 11-bit counter lets a 1024-cycle window on the fastest clock hit the saturation value of 2047, which a 16-bit counter could never reach. Pre-divider settings of 1, 3 and 0 show the divide-by-(d+1) rule against the same clocks.

// File: rtl/fm_pkg.sv
`timescale 1ns/100ps
// fm_pkg: shared field positions, widths and the reference-side state type
// for the frequency meter. Field positions that software decodes are kept
// fixed here; everything else derives from them.
package fm_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 32;
    localparam int EN_BIT   = 0;
    localparam int RUN_BIT  = 1;
    localparam int LOAD_LSB = 16;
    localparam int LOAD_W   = 10;
    localparam int MODE_W   = 2;
    localparam int SRC_LSB  = 8;
    localparam int SRC_W    = 7;
    localparam int DIV_LSB  = 24;
    localparam int DIV_W    = 8;
    localparam logic [LOAD_W-1:0] DEF_LOAD = LOAD_W'(511);

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_WIN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_SEL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ABORT = 2'd3
    } fm_state_t;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/100ps
// fm_sync: multi-flop level synchronizer into the domain of clk.
// Assumes the input is a level that stays put for several destination cycles.
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_clk_sel.sv
`timescale 1ns/100ps
// fm_clk_sel: AND-OR clock selector over the monitored clocks.
// Assumes the code changes only while no measurement is in progress, so a
// glitch on the selected clock cannot corrupt a count. code_ok flags a code
// that names an existing input.
module fm_clk_sel #(
    parameter int N_SRC = 2,
    parameter int SRC_W = 7
) (
    input  logic [N_SRC-1:0] clk_in,
    input  logic [SRC_W-1:0] code,
    output logic             clk_out,
    output logic             code_ok
);
    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] term;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i]  = (code == SRC_W'(i));
        assign term[i] = clk_in[i] & hit[i];
    end

    assign clk_out = |term;
    assign code_ok = |hit;
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/100ps
// fm_edge_counter: monitored-domain half of the meter. Synchronizes the gate
// with two flops, clears on the gate's arrival, counts prescaled edges while
// the synchronized gate is high (saturating), and flips done_tog when it
// falls. Assumes the gate stays high for at least three monitored cycles and
// that div is static while the gate is high.
module fm_edge_counter #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_async,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] count,
    output logic             done_tog
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             gate_s1, gate_s2;
    logic [DIV_W-1:0] pre_cnt;

    // two-flop capture of the reference-domain gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_s1 <= 1'b0;
            gate_s2 <= 1'b0;
        end else begin
            gate_s1 <= gate_async;
            gate_s2 <= gate_s1;
        end
    end

    // clear on gate arrival, prescale and count while gated, hold afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            count   <= '0;
        end else if (gate_s1 && !gate_s2) begin
            pre_cnt <= '0;
            count   <= '0;
        end else if (gate_s2) begin
            if (pre_cnt == div) begin
                pre_cnt <= '0;
                if (count != CNT_MAX) count <= count + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // flip the completion toggle as the synchronized gate drops
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_tog <= 1'b0;
        else if (gate_s2 && !gate_s1)  done_tog <= ~done_tog;
    end
endmodule

// File: rtl/fm_ref_ctrl.sv
`timescale 1ns/100ps
// fm_ref_ctrl: reference-domain register port and measurement sequencer.
// Holds the control and configuration fields, times the gate window,
// consumes the synchronized completion toggle and captures the result.
// Assumes mon_count is frozen whenever the synchronized toggle differs from
// the last value seen.
module fm_ref_ctrl
    import fm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              src_ok,
    input  logic              tog_sync,
    input  logic [CNT_W-1:0]  mon_count,
    output logic              gate,
    output logic              enable,
    output logic              run,
    output logic [LOAD_W-1:0] load,
    output logic [MODE_W-1:0] mode,
    output logic [SRC_W-1:0]  src,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  result
);
    fm_state_t         state;
    logic [LOAD_W-1:0] win_cnt;
    logic              tog_seen;
    logic              ctrl_wr, start_req, abort_req, cfg_open, tog_new;
    logic              unused_wdata_bits;

    assign ctrl_wr   = reg_we && (reg_addr == A_CTRL);
    assign cfg_open  = (state == ST_IDLE);
    assign start_req = ctrl_wr && reg_wdata[RUN_BIT] && reg_wdata[EN_BIT] && enable
                       && cfg_open && (mode == '0) && src_ok;
    assign abort_req = ctrl_wr && !reg_wdata[EN_BIT];
    assign tog_new   = (tog_sync != tog_seen);
    assign run       = (state == ST_GATE) || (state == ST_WAIT);
    assign unused_wdata_bits = ^reg_wdata;

    // enable bit follows every control write
    always_ff @(posedge clk) begin
        if (!rst_n)       enable <= 1'b0;
        else if (ctrl_wr) enable <= reg_wdata[EN_BIT];
    end

    // configuration fields accept writes only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load <= DEF_LOAD;
            mode <= '0;
            src  <= '0;
            div  <= '0;
        end else if (reg_we && cfg_open) begin
            unique case (reg_addr)
                A_WIN: load <= reg_wdata[LOAD_LSB +: LOAD_W];
                A_SEL: begin
                    mode <= reg_wdata[MODE_W-1:0];
                    src  <= reg_wdata[SRC_LSB +: SRC_W];
                end
                A_DIV: div <= reg_wdata[DIV_LSB +: DIV_W];
                default: ;
            endcase
        end
    end

    // sequencer: gate window, completion wait, abort drain, result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            gate     <= 1'b0;
            win_cnt  <= '0;
            tog_seen <= 1'b0;
            result   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state   <= ST_GATE;
                        gate    <= 1'b1;
                        win_cnt <= load;
                    end
                end
                ST_GATE: begin
                    if (win_cnt == '0) begin
                        gate  <= 1'b0;
                        state <= abort_req ? ST_ABORT : ST_WAIT;
                    end else begin
                        win_cnt <= win_cnt - 1'b1;
                        if (abort_req) state <= ST_ABORT;
                    end
                end
                ST_WAIT: begin
                    if (tog_new) begin
                        tog_seen <= tog_sync;
                        state    <= ST_IDLE;
                        if (!abort_req) result <= mon_count;
                    end else if (abort_req) begin
                        state <= ST_ABORT;
                    end
                end
                ST_ABORT: begin
                    if (gate) begin
                        if (win_cnt == '0) gate <= 1'b0;
                        else               win_cnt <= win_cnt - 1'b1;
                    end else if (tog_new) begin
                        tog_seen <= tog_sync;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // read multiplexer over the four words
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[EN_BIT]  = enable;
                reg_rdata[RUN_BIT] = run;
            end
            A_WIN: begin
                reg_rdata[LOAD_LSB +: LOAD_W] = load;
                reg_rdata[CNT_W-1:0]          = result;
            end
            A_SEL: begin
                reg_rdata[MODE_W-1:0]       = mode;
                reg_rdata[SRC_LSB +: SRC_W] = src;
            end
            A_DIV: reg_rdata[DIV_LSB +: DIV_W] = div;
            default: ;
        endcase
    end
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/100ps
// freq_meter: top of the reference-gated frequency meter. Ties the register
// sequencer, source selector, monitored-side counter and return synchronizer
// together. Assumes CNT_W <= 16 so the result fits below the window field,
// and that every monitored clock sees a gate of load+1 reference cycles as at
// least three of its own cycles.
module freq_meter
    import fm_pkg::*;
#(
    parameter int N_SRC = 2,
    parameter int CNT_W = 16
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  mon_clk,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic              gate_ref, ctl_enable, ctl_run, src_ok, sel_clk;
    logic              done_tog_mon, done_tog_ref;
    logic [LOAD_W-1:0] cfg_load;
    logic [MODE_W-1:0] cfg_mode;
    logic [SRC_W-1:0]  cfg_src;
    logic [DIV_W-1:0]  cfg_div;
    logic [CNT_W-1:0]  mon_count, meas_result;

    fm_ref_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(ref_clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_ok(src_ok), .tog_sync(done_tog_ref),
        .mon_count(mon_count), .gate(gate_ref), .enable(ctl_enable),
        .run(ctl_run), .load(cfg_load), .mode(cfg_mode), .src(cfg_src),
        .div(cfg_div), .result(meas_result)
    );

    fm_clk_sel #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_sel (
        .clk_in(mon_clk), .code(cfg_src), .clk_out(sel_clk), .code_ok(src_ok)
    );

    fm_edge_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
        .clk(sel_clk), .rst_n(rst_n), .gate_async(gate_ref), .div(cfg_div),
        .count(mon_count), .done_tog(done_tog_mon)
    );

    fm_sync #(.STAGES(2)) u_done_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(done_tog_mon), .q(done_tog_ref)
    );
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/100ps
// fm_checker: reference-domain properties of the meter, bound into the top.
// Assumes nothing beyond the top's own ports and state.
module fm_checker
    import fm_pkg::*;
#(
    parameter int N_SRC = 2,
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate,
    input logic              enable,
    input logic              run,
    input logic [LOAD_W-1:0] load,
    input logic [MODE_W-1:0] mode,
    input logic [SRC_W-1:0]  src,
    input logic [DIV_W-1:0]  div,
    input logic [CNT_W-1:0]  result
);
    logic [LOAD_W:0] gate_len;

    // count the reference cycles the gate has been high
    always_ff @(posedge clk) begin
        if (!rst_n)    gate_len <= '0;
        else if (gate) gate_len <= gate_len + 1'b1;
        else           gate_len <= '0;
    end

    assert_gate_with_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> run);
    assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(enable));
    assert_window_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && run) |-> (gate_len == ({1'b0, load} + 1'b1)));
    assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(src) < N_SRC));
    assert_clock_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(mode) == '0));
    assert_result_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(run));
    assert_run_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !run);
    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(load) && $stable(mode) && $stable(src) && $stable(div)));
endmodule

bind freq_meter fm_checker #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_fm_chk (
    .clk(ref_clk), .rst_n(rst_n), .gate(gate_ref), .enable(ctl_enable),
    .run(ctl_run), .load(cfg_load), .mode(cfg_mode), .src(cfg_src),
    .div(cfg_div), .result(meas_result)
);

// File: tb/tb_freq_meter.sv
`timescale 1ns/100ps
// tb_freq_meter: vector table of measurements followed by directed tests
// for reset, refusals, configuration lock and abort.
module tb_freq_meter;
    localparam int N_SRC = 4;
    localparam int CNT_W = 11;

    typedef struct packed {
        logic [7:0]  src;
        logic [7:0]  div;
        logic [15:0] load;
        logic [15:0] exp;
        logic [7:0]  tol;
    } vec_t;

    // reference 8 ns; monitored periods 4, 10, 3, 16 ns
    localparam vec_t VECS [7] = '{
        '{8'd0, 8'd0, 16'd511,  16'd1024, 8'd2},  // R4 ratio 2
        '{8'd1, 8'd0, 16'd511,  16'd410,  8'd2},  // R5 source 1, ratio 0.8
        '{8'd2, 8'd0, 16'd255,  16'd683,  8'd2},  // R5 source 2, window 256
        '{8'd3, 8'd0, 16'd511,  16'd256,  8'd2},  // R5 source 3, ratio 0.5
        '{8'd0, 8'd3, 16'd511,  16'd256,  8'd2},  // R7 divide by 4
        '{8'd1, 8'd1, 16'd99,   16'd40,   8'd2},  // R7 divide by 2, short window
        '{8'd2, 8'd0, 16'd1023, 16'd2047, 8'd0}   // R9 saturation
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mon_clk = 4'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          finished = 1'b0;

    always #4    clk = ~clk;
    always #2    mon_clk[0] = ~mon_clk[0];
    always #5    mon_clk[1] = ~mon_clk[1];
    always #1.5  mon_clk[2] = ~mon_clk[2];
    always #8    mon_clk[3] = ~mon_clk[3];

    freq_meter #(.N_SRC(N_SRC), .CNT_W(CNT_W)) dut (
        .ref_clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input int act, input int exp, input int tol);
        n_checks++;
        if (act > exp + tol || act < exp - tol) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] d;
        d = 32'h2;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, d);
            if (!d[1]) break;
        end
        check(tag, int'(d[1]), 0, 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] kept;
        repeat (10) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 control word", int'(d), 0, 0);
        rd(2'd1, d); check("R1 window/result word", int'(d), 511 << 16, 0);
        rd(2'd2, d); check("R1 mode/source word", int'(d), 0, 0);
        rd(2'd3, d); check("R1 divisor word", int'(d), 0, 0);

        // R3 run without prior enable
        wr(2'd0, 32'h2);
        rd(2'd0, d); check("R3 run alone", int'(d), 0, 0);
        wr(2'd0, 32'h3);
        rd(2'd0, d); check("R3 enable and run together", int'(d), 1, 0);

        // R2 start and run readback
        wr(2'd0, 32'h3);
        rd(2'd0, d); check("R2 run reads 1 after start", int'(d), 3, 0);
        wait_done("R8 run self-clears");

        // vector table
        for (int i = 0; i < 7; i++) begin
            string tag;
            if (VECS[i].tol == 0)       tag = $sformatf("R9 vector %0d", i);
            else if (VECS[i].div != 0)  tag = $sformatf("R7 vector %0d", i);
            else if (VECS[i].src != 0)  tag = $sformatf("R5 vector %0d", i);
            else                        tag = $sformatf("R4 vector %0d", i);
            wr(2'd1, {6'd0, VECS[i].load[9:0], 16'd0});
            wr(2'd2, {16'd0, VECS[i].src, 8'd0});
            wr(2'd3, {VECS[i].div, 24'd0});
            wr(2'd0, 32'h1);
            wr(2'd0, 32'h3);
            wait_done({tag, " completion"});
            rd(2'd1, d);
            check(tag, int'(d[15:0]), int'(VECS[i].exp), int'(VECS[i].tol));
        end
        wr(2'd3, 32'd0);

        // R6 non-zero mode refuses run
        wr(2'd2, 32'h0000_0001);
        wr(2'd0, 32'h3);
        rd(2'd0, d); check("R6 mode 01 refuses run", int'(d), 1, 0);

        // R5 out-of-range source codes refuse run
        wr(2'd2, 32'h0000_0400);
        wr(2'd0, 32'h3);
        rd(2'd0, d); check("R5 code 4 refused", int'(d), 1, 0);
        wr(2'd2, 32'h0000_6400);
        wr(2'd0, 32'h3);
        rd(2'd0, d); check("R5 code 100 refused", int'(d), 1, 0);

        // R11 configuration locked while running
        wr(2'd2, 32'h0000_0300);
        wr(2'd1, {6'd0, 10'd1023, 16'd0});
        wr(2'd0, 32'h3);
        wr(2'd1, {6'd0, 10'd5, 16'd0});
        wr(2'd2, 32'h0000_0100);
        wr(2'd3, 32'h0700_0000);
        rd(2'd1, d); check("R11 window kept", int'(d[25:16]), 1023, 0);
        rd(2'd2, d); check("R11 source kept", int'(d), 32'h300, 0);
        rd(2'd3, d); check("R11 divisor kept", int'(d), 0, 0);
        wait_done("R11 completion");
        rd(2'd1, d); check("R11 result from locked setup", int'(d[15:0]), 512, 2);
        kept = d;

        // R10 abort mid-window
        wr(2'd0, 32'h3);
        repeat (100) @(posedge clk);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R10 run forced low", int'(d), 0, 0);
        rd(2'd1, d); check("R10 result kept", int'(d[15:0]), int'(kept[15:0]), 0);
        repeat (1200) @(posedge clk);
        rd(2'd1, d); check("R10 result kept after drain", int'(d[15:0]), int'(kept[15:0]), 0);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h3);
        wait_done("R10 completion after abort");
        rd(2'd1, d); check("R10 measurement after abort", int'(d[15:0]), 512, 2);

        finish_up();
    end
endmodule